// File: doc/BRIEF.md
# Strobed Serial Register-File Slave

The block is the target end of a four-wire serial link: a serial clock, a data line from the master, a data line back to the master, and an active-low strobe. Through this link a master reaches a small bank of 32-bit registers. Two of them are general read-write words, one is a live copy of a switch input, one is a control word whose bit 0 raises a system reset request, and one is a fixed version constant. All link pins are sampled with the faster system clock, which must run at least four times the serial clock rate.

A frame is delimited by a single serial clock with the strobe held low, and that clock carries the direction bit. To write, the master shifts 32 data bits and then 8 address bits, and sets direction to 1 on the strobed clock. To read, the master shifts 8 address bits, sets direction to 0 on the strobed clock, and then gives 32 more clocks. On those clocks it samples the returned word while the clock is high. Every field travels most-significant bit first.

Top module: `strobe_regfile_slave`

## Requirements
- R1: Data-in is captured on each rising edge of the serial clock, MSB first. A strobed rising edge with direction bit 1 writes the 32 bits received before the 8 address bits into the addressed register. The writable registers are address 0x00 (mode), address 0x02 (mux) and address 0x80 (reset control).
- R2: A strobed rising edge with direction bit 0 starts a read of the address held in the last 8 bits received. The register's MSB is on data-out before the first return clock. Each falling edge of the serial clock after the strobed clock moves data-out on to the next lower bit.
- R3: A read of address 0x08 returns the current switch input. A read of address 0xFF returns the VERSION parameter.
- R4: A write to address 0x08, to address 0xFF or to any unmapped address changes no register.
- R5: A read of any address outside 0x00, 0x02, 0x08, 0x80 and 0xFF returns zero.
- R6: Rising edges that arrive while the strobe is high only shift bits in. They never write a register.
- R7: Only the most recent 40 bits matter. Bits shifted in before a frame's own 41 write bits (or 9 read bits) have no effect.
- R8: The system reset request output equals bit 0 of the reset-control register. Writing 1 asserts it, and writing 0 releases it.
- R9: While the synchronous active-low reset is asserted, mode, mux and reset control are cleared, data-out goes to 0 and the reset request goes to 0.
- R10: After the 32nd return bit has been shifted past, data-out reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the master |
| ser_din | input | 1 | Serial data from the master |
| ser_strobe_n | input | 1 | Active-low frame strobe, low only on the direction clock |
| ser_dout | output | 1 | Serial data returned to the master |
| switch_in | input | DATA_W | Switch word reported at address 0x08 |
| sys_reset_req | output | 1 | System reset request, bit 0 of reset control |

## Verification
The hardest case to reach from the ports is a stream that does not line up with a frame. This covers stale bits left in the input shifter, leading junk ahead of a frame, and a full 41-bit write pattern sent with the strobe never low. The bench bit-bangs each of these at the pins. It then reads back through ordinary read frames to show that only the last 40 bits and the strobed clock decide what happens. It also samples data-out just before the first return clock, which checks that the falling edge of the strobed clock does not skip the MSB.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADR_MODE = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_MUX  = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_SW   = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_RSTC = 8'h80;
  localparam logic [ADDR_W-1:0] ADR_VER  = 8'hFF;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_MUX, SEL_SW, SEL_RSTC, SEL_VER
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      ADR_MODE: return SEL_MODE;
      ADR_MUX:  return SEL_MUX;
      ADR_SW:   return SEL_SW;
      ADR_RSTC: return SEL_RSTC;
      ADR_VER:  return SEL_VER;
      default:  return SEL_NONE;
    endcase
  endfunction

  function automatic logic is_writable(input reg_sel_e s);
    return (s == SEL_MODE) || (s == SEL_MUX) || (s == SEL_RSTC);
  endfunction
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= RESET_VAL;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/srs_frame.sv
module srs_frame #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              din_s,
  input  logic              stb_n_s,
  output logic              sck_rise,
  output logic              sck_fall,
  output logic              wr_evt,
  output logic              rd_evt,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [DATA_W-1:0] frm_data
);
  localparam int FRAME_W = DATA_W + ADDR_W;

  logic               sck_prev;
  logic [FRAME_W-1:0] shift_q;
  logic               strobed;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_prev <= 1'b0;
    else sck_prev <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_prev;
  assign sck_fall = ~sck_s & sck_prev;
  assign strobed  = sck_rise & ~stb_n_s;

  // Only the direction bit is strobed; it is not shifted in.
  always_ff @(posedge clk) begin
    if (!rst_n) shift_q <= '0;
    else if (sck_rise && stb_n_s) shift_q <= {shift_q[FRAME_W-2:0], din_s};
  end

  assign frm_addr = shift_q[ADDR_W-1:0];
  assign frm_data = shift_q[FRAME_W-1:ADDR_W];
  assign wr_evt   = strobed & din_s;
  assign rd_evt   = strobed & ~din_s;
endmodule

// File: rtl/srs_regbank.sv
module srs_regbank
  import srs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] VERSION = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] frm_addr,
  input  logic [DATA_W-1:0] frm_data,
  input  logic [DATA_W-1:0] switch_in,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] mux_q,
  output logic [DATA_W-1:0] rstc_q
);
  reg_sel_e sel;
  logic     wr_ok;

  assign sel   = decode_addr(frm_addr);
  assign wr_ok = wr_evt && is_writable(sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      mux_q  <= '0;
      rstc_q <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_MODE: mode_q <= frm_data;
        SEL_MUX:  mux_q  <= frm_data;
        SEL_RSTC: rstc_q <= frm_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_MODE: rd_word = mode_q;
      SEL_MUX:  rd_word = mux_q;
      SEL_SW:   rd_word = switch_in;
      SEL_RSTC: rd_word = rstc_q;
      SEL_VER:  rd_word = VERSION;
      default:  rd_word = '0;
    endcase
  end
endmodule

// File: rtl/srs_readout.sv
module srs_readout #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] rd_word,
  output logic              ser_dout
);
  logic [DATA_W-1:0] out_q;
  logic              hold_q;

  // hold_q keeps the MSB through the falling edge of the strobed clock.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      hold_q <= 1'b0;
    end else if (rd_evt) begin
      out_q  <= rd_word;
      hold_q <= 1'b1;
    end else if (sck_fall) begin
      if (hold_q) hold_q <= 1'b0;
      else out_q <= {out_q[DATA_W-2:0], 1'b0};
    end
  end

  assign ser_dout = out_q[DATA_W-1];
endmodule

// File: rtl/strobe_regfile_slave.sv
module strobe_regfile_slave
  import srs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] VERSION = 32'h5A17_0103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_strobe_n,
  output logic              ser_dout,
  input  logic [DATA_W-1:0] switch_in,
  output logic              sys_reset_req
);
  logic              sck_s, din_s, stb_n_s;
  logic              sck_rise, sck_fall, wr_evt, rd_evt;
  logic [ADDR_W-1:0] frm_addr;
  logic [DATA_W-1:0] frm_data, rd_word, mode_q, mux_q, rstc_q;

  srs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_strobe_n, ser_din, ser_clk}),
    .q({stb_n_s, din_s, sck_s})
  );

  srs_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .din_s(din_s), .stb_n_s(stb_n_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .frm_addr(frm_addr), .frm_data(frm_data)
  );

  srs_regbank #(.DATA_W(DATA_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .frm_addr(frm_addr),
    .frm_data(frm_data), .switch_in(switch_in), .rd_word(rd_word),
    .mode_q(mode_q), .mux_q(mux_q), .rstc_q(rstc_q)
  );

  srs_readout #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .sck_fall(sck_fall),
    .rd_word(rd_word), .ser_dout(ser_dout)
  );

  assign sys_reset_req = rstc_q[0];
endmodule

// File: rtl/srs_checker.sv
module srs_checker
  import srs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck_rise,
  input logic              sck_fall,
  input logic              wr_evt,
  input logic              rd_evt,
  input logic [ADDR_W-1:0] frm_addr,
  input logic [DATA_W-1:0] frm_data,
  input logic [DATA_W-1:0] mode_q,
  input logic              ser_dout,
  input logic              sys_reset_req
);
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && frm_addr == ADR_MODE) |=> mode_q == $past(frm_data)); // R1

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_evt && frm_addr == ADR_MODE) |=> $stable(mode_q)); // R4

  AST_DOUT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_fall || rd_evt) |=> $stable(ser_dout)); // R2

  AST_EVT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt || rd_evt) |-> sck_rise); // R6

  AST_REQ_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && frm_addr == ADR_RSTC) |=> sys_reset_req == $past(frm_data[0])); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_evt && frm_addr == ADR_RSTC) |=> $stable(sys_reset_req)); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (mode_q == '0 && !ser_dout && !sys_reset_req)); // R9
endmodule

bind strobe_regfile_slave srs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
  .wr_evt(wr_evt), .rd_evt(rd_evt), .frm_addr(frm_addr), .frm_data(frm_data),
  .mode_q(mode_q), .ser_dout(ser_dout), .sys_reset_req(sys_reset_req)
);

// File: tb/tb_strobe_regfile_slave.sv
module tb_strobe_regfile_slave;
  localparam int CLK_P = 10;
  localparam int HALF = 4;
  localparam logic [31:0] VER = 32'h5A17_0103;

  logic clk = 0, rst_n = 0, ser_clk = 0, ser_din = 0, ser_strobe_n = 1;
  logic ser_dout, sys_reset_req;
  logic [31:0] switch_in = 32'hC3A5_0F96;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];
  string       tag_q[$];

  strobe_regfile_slave dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_strobe_n(ser_strobe_n), .ser_dout(ser_dout), .switch_in(switch_in),
    .sys_reset_req(sys_reset_req)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sbit(input logic d, input logic stb_n);
    ser_din = d; ser_strobe_n = stb_n;
    wait_clks(HALF);
    ser_clk = 1;
    wait_clks(HALF);
    ser_clk = 0;
  endtask

  task automatic ser_write(input logic [7:0] a, input logic [31:0] d, input bit strobe = 1);
    for (int i = 31; i >= 0; i--) sbit(d[i], 1'b1);
    for (int i = 7; i >= 0; i--) sbit(a[i], 1'b1);
    sbit(1'b1, strobe ? 1'b0 : 1'b1);
    ser_strobe_n = 1;
    wait_clks(HALF + 4);
  endtask

  // Driver: pushes the expectation, then collects the returned word.
  task automatic ser_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] w;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) sbit(a[i], 1'b1);
    sbit(1'b0, 1'b0);
    ser_strobe_n = 1;
    wait_clks(HALF);
    @(negedge clk);
    check("R2 msb before first return clock", {31'b0, ser_dout}, {31'b0, exp[31]});
    for (int i = 31; i >= 0; i--) begin
      ser_clk = 1;
      wait_clks(HALF);
      @(negedge clk);
      w[i] = ser_dout;
      @(posedge clk);
      ser_clk = 0;
      wait_clks(HALF);
    end
    @(negedge clk);
    check("R10 dout zero after word", {31'b0, ser_dout}, 32'h0);
    got_q.push_back(w);
  endtask

  // Monitor: compares returned words with the queued expectations.
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [31:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, g, e);
    end
  end

  task automatic do_reset();
    rst_n = 0;
    wait_clks(4);
    @(negedge clk);
    check("R9 dout in reset", {31'b0, ser_dout}, 32'h0);
    check("R9 reset request in reset", {31'b0, sys_reset_req}, 32'h0);
    rst_n = 1;
    wait_clks(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired got=running exp=finished");
    finish_run();
  end

  initial begin
    do_reset();
    ser_read(8'h00, 32'h0, "R9 mode after reset");
    ser_read(8'h02, 32'h0, "R9 mux after reset");
    ser_read(8'h80, 32'h0, "R9 reset control after reset");

    ser_write(8'h00, 32'h8000_0001);
    ser_write(8'h02, 32'h1234_5678);
    ser_read(8'h00, 32'h8000_0001, "R1 mode write");
    ser_read(8'h02, 32'h1234_5678, "R1 mux write");

    ser_read(8'h08, 32'hC3A5_0F96, "R3 switch read");
    switch_in = 32'h0000_FFFF;
    ser_read(8'h08, 32'h0000_FFFF, "R3 switch follows input");
    ser_read(8'hFF, VER, "R3 version read");

    ser_write(8'h08, 32'hDEAD_BEEF);
    ser_write(8'hFF, 32'hDEAD_BEEF);
    ser_write(8'h05, 32'hDEAD_BEEF);
    ser_read(8'h08, 32'h0000_FFFF, "R4 switch unchanged by write");
    ser_read(8'hFF, VER, "R4 version unchanged by write");
    ser_read(8'h00, 32'h8000_0001, "R4 mode unchanged by unmapped write");
    ser_read(8'h02, 32'h1234_5678, "R4 mux unchanged by unmapped write");

    ser_read(8'h05, 32'h0, "R5 unmapped 0x05 reads zero");
    ser_read(8'h01, 32'h0, "R5 unmapped 0x01 reads zero");

    ser_write(8'h00, 32'hFFFF_0000, 0);
    ser_read(8'h00, 32'h8000_0001, "R6 no strobe no write");

    for (int i = 0; i < 12; i++) sbit(i[0], 1'b1);
    ser_write(8'h02, 32'hA5A5_5A5A);
    ser_read(8'h02, 32'hA5A5_5A5A, "R7 leading junk ignored");

    ser_write(8'h80, 32'h0000_0001);
    @(negedge clk);
    check("R8 reset request asserted", {31'b0, sys_reset_req}, 32'h1);
    ser_read(8'h80, 32'h0000_0001, "R8 reset control readback");
    ser_write(8'h80, 32'h0000_0000);
    @(negedge clk);
    check("R8 reset request released", {31'b0, sys_reset_req}, 32'h0);
    ser_write(8'h80, 32'h0000_0003);

    do_reset();
    ser_read(8'h00, 32'h0, "R9 mode cleared by second reset");
    ser_read(8'h80, 32'h0, "R9 reset control cleared by second reset");
    @(negedge clk);
    check("R9 request low after second reset", {31'b0, sys_reset_req}, 32'h0);

    wait_clks(4);
    finish_run();
  end
endmodule